// File: doc/BRIEF.md
# Fractional-N Multi-Modulus Divider Controller

This block is the digital counting engine of a fractional-N synthesizer's main loop. It runs on the output of an external multi-modulus prescaler, so one clock cycle is one prescaler output cycle. It drives two modulus-control lines, `fb1` and `fb2`, that tell the prescaler which of up to four division ratios to use. Each main-divider cycle walks through a series of ratio phases. The length of each phase comes from a set of programmed counts and a 2-bit prescaler-type code. On the last input cycle of every main-divider cycle the block raises a one-cycle pulse toward the phase detector.

At the end of every main cycle a 3-bit increment is added into a fractional accumulator that wraps at 5 or at 8. A wrap moves one input cycle out of the first phase and into the second phase of the following main cycle. Because the second ratio is one higher than the first, the divide ratio grows by one on that cycle. The accumulator value is brought out so that compensation logic can scale a correction current from it.

New phase counts and a new prescaler type arrive over a valid/ready handshake. Ready is high only in the final input cycle of a main cycle, or at any time while the block is disabled. A request that arrives outside that window is back-pressured: the source must hold `cfg_valid` and the data steady until `cfg_ready` rises. The data transfers on the clock edge where both are high and governs the next main cycle as a whole. A change of ratio therefore never splits a cycle. The increment and the modulus select are plain control inputs, sampled on each end-of-cycle edge.

Top module: `fracn_mmd_ctrl`

## Requirements
- R1: The modulus-control pair {fb1,fb2} is 10 in phase P1, 00 in P2, 01 in P3 and 11 in P4. The phases run in the order P1, P2, P3, P4, and any phase of length zero is skipped.
- R2: Phase P1 lasts NM1+2 input cycles, or NM1+1 when the overflow flag of the current main cycle is set. NM1 is 12 bits wide.
- R3: Phase P2 lasts NM2 input cycles, plus one when the overflow flag is set. All 8 bits of NM2 count when the type code is 01. For every other type code only NM2[3:0] counts. A length of zero skips the phase.
- R4: Phase P3 lasts NM3+1 cycles and occurs only for type codes 10 and 11. Phase P4 lasts NM4+1 cycles and occurs only for type codes 11 and 00, so code 00 skips P3.
- R5: `div_pulse` is high in exactly the last input cycle of each main cycle and is never high for two cycles in a row.
- R6: On each end-of-cycle edge the accumulator is updated with the values of `frac_inc` and `frac_mod8` present at that edge. Let s = acc + frac_inc and Q = 8 if `frac_mod8` is 1, else 5. If s >= Q, the new acc is (s-Q) mod 8 and an overflow is flagged; otherwise the new acc is s and no overflow is flagged. `frac_acc` shows acc.
- R7: The overflow flag set at the end of one main cycle governs only the next main cycle. It changes only on end-of-cycle edges.
- R8: `cfg_ready` is high while enabled only in the last input cycle of a main cycle, and is always high while disabled. The work registers change only on an edge with `cfg_valid` and `cfg_ready` both high, and the new values take effect from the next main cycle. A request held while ready is low changes nothing.
- R9: One edge after `en` is sampled low, `fb1`, `fb2` and `div_pulse` are 0. The accumulator and the overflow flag are cleared and stay 0 whatever `frac_inc` is. Once `en` returns, the first main cycle starts in P1 using the work registers.
- R10: Asynchronous reset (`rst_n` low) clears the outputs and the accumulator. It sets the work registers to type code 01 with all counts 0, so the first enabled main cycle is two cycles of P1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Prescaler output clock, one edge per input cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Main divider enable |
| cfg_valid | input | 1 | New work-register set offered |
| cfg_ready | output | 1 | Safe load window open |
| cfg_ptype | input | 2 | Prescaler type code (01, 10, 11, 00) |
| cfg_nm1 | input | 12 | Phase P1 count |
| cfg_nm2 | input | 8 | Phase P2 count |
| cfg_nm3 | input | 4 | Phase P3 count |
| cfg_nm4 | input | 4 | Phase P4 count |
| frac_inc | input | 3 | Fractional increment per main cycle |
| frac_mod8 | input | 1 | Accumulator modulus: 1 selects 8, 0 selects 5 |
| fb1 | output | 1 | Modulus control line 1 |
| fb2 | output | 1 | Modulus control line 2 |
| div_pulse | output | 1 | End-of-main-cycle pulse to the phase detector |
| frac_acc | output | 3 | Fractional accumulator contents |

## Verification
Directed type codes separate the four phase layouts. Code 00 shows that P3 is skipped, and code 10 with a high-nibble-heavy NM2 shows that only the low nibble counts. An NM2 of zero tells an omitted P2 from a one-cycle P2 that appears only after overflow, and the 4095 count exercises the full P1 range. Fixed increments under each modulus make the overflow pattern predictable, so a misplaced extra cycle (wrong phase, or wrong main cycle) shows up as a sequence mismatch. Seeded random type codes, counts, increments and load requests, with the load held through the closed window, then cover mixes of back-pressure, modulus switching and overflow that the directed cases do not reach.

// File: rtl/fracn_pkg.sv
package fracn_pkg;

  localparam int PT_W         = 2;
  localparam int NM1_W        = 12;
  localparam int NM2_W        = 8;
  localparam int NM2_NARROW_W = 4;
  localparam int NM34_W       = 4;
  localparam int ACC_W        = 3;
  localparam int CNT_W        = NM1_W + 1;
  localparam int N_PHASE      = 4;

  localparam logic [PT_W-1:0] PT_DIV2   = 2'b01;
  localparam logic [PT_W-1:0] PT_DIV3   = 2'b10;
  localparam logic [PT_W-1:0] PT_DIV4   = 2'b11;
  localparam logic [PT_W-1:0] PT_DIV4N3 = 2'b00;

  typedef enum logic [1:0] {PH_P1 = 2'd0, PH_P2 = 2'd1, PH_P3 = 2'd2, PH_P4 = 2'd3} phase_e;

  typedef struct packed {
    logic [PT_W-1:0]   ptype;
    logic [NM1_W-1:0]  nm1;
    logic [NM2_W-1:0]  nm2;
    logic [NM34_W-1:0] nm3;
    logic [NM34_W-1:0] nm4;
  } work_cfg_t;

  localparam work_cfg_t CFG_RESET = '{ptype: PT_DIV2, nm1: '0, nm2: '0, nm3: '0, nm4: '0};

  // {fb1, fb2} per phase
  function automatic logic [1:0] fb_code(phase_e p);
    case (p)
      PH_P1:   fb_code = 2'b10;
      PH_P2:   fb_code = 2'b00;
      PH_P3:   fb_code = 2'b01;
      default: fb_code = 2'b11;
    endcase
  endfunction

  // Number of input cycles spent in one phase; zero means the phase is absent
  function automatic logic [CNT_W-1:0] phase_len(work_cfg_t c, logic ovf, logic [1:0] idx);
    logic [NM2_W-1:0] n2;
    n2 = (c.ptype == PT_DIV2) ? c.nm2 : NM2_W'(c.nm2[NM2_NARROW_W-1:0]);
    case (idx)
      2'd0: phase_len = CNT_W'(c.nm1) + (ovf ? CNT_W'(1) : CNT_W'(2));
      2'd1: phase_len = CNT_W'(n2) + CNT_W'(ovf);
      2'd2: phase_len = c.ptype[1] ? CNT_W'(c.nm3) + CNT_W'(1) : '0;
      default: phase_len = ((c.ptype == PT_DIV4) || (c.ptype == PT_DIV4N3)) ?
                           CNT_W'(c.nm4) + CNT_W'(1) : '0;
    endcase
  endfunction

endpackage

// File: rtl/fracn_work_regs.sv
module fracn_work_regs
  import fracn_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  work_cfg_t in_cfg,
  input  logic      load_valid,
  input  logic      load_ready,
  output work_cfg_t work_cfg,
  output work_cfg_t next_cfg
);

  work_cfg_t work_q;
  logic      accept;

  assign accept   = load_valid & load_ready;
  assign next_cfg = accept ? in_cfg : work_q;
  assign work_cfg = work_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      work_q <= CFG_RESET;
    else if (accept) work_q <= in_cfg;
  end

  // R8
  work_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(load_valid && load_ready) |=> $stable(work_q));

endmodule

// File: rtl/fracn_frac_accum.sv
module fracn_frac_accum
  import fracn_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             step,
  input  logic [ACC_W-1:0] inc,
  input  logic             mod8,
  output logic [ACC_W-1:0] acc,
  output logic             ovf_flag,
  output logic             ovf_new
);

  localparam logic [ACC_W:0] Q_BIN = (ACC_W+1)'(1 << ACC_W);
  localparam logic [ACC_W:0] Q_ALT = (ACC_W+1)'(5);

  logic [ACC_W-1:0] acc_q;
  logic             ovf_q;
  logic [ACC_W:0]   sum;
  logic [ACC_W:0]   q;
  logic [ACC_W:0]   diff;
  logic [ACC_W-1:0] acc_nx;

  assign q       = mod8 ? Q_BIN : Q_ALT;
  assign sum     = {1'b0, acc_q} + {1'b0, inc};
  assign ovf_new = (sum >= q);
  assign diff    = sum - q;
  assign acc_nx  = ovf_new ? diff[ACC_W-1:0] : sum[ACC_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      ovf_q <= 1'b0;
    end else if (clr) begin
      acc_q <= '0;
      ovf_q <= 1'b0;
    end else if (step) begin
      acc_q <= acc_nx;
      ovf_q <= ovf_new;
    end
  end

  assign acc      = acc_q;
  assign ovf_flag = ovf_q;

  // R6
  acc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !step) |=> $stable(acc_q));

  // R7
  ovf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !step) |=> $stable(ovf_q));

  // R6
  mod5_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !clr && !mod8 && acc_q < ACC_W'(5) && inc < ACC_W'(5)) |=> (acc_q < ACC_W'(5)));

endmodule

// File: rtl/fracn_phase_seq.sv
module fracn_phase_seq
  import fracn_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  work_cfg_t        work_cfg,
  input  work_cfg_t        next_cfg,
  input  logic             ovf_cur,
  input  logic             start_ovf,
  output phase_e           phase,
  output logic             cyc_end
);

  phase_e           ph;
  logic [CNT_W-1:0] rem;
  logic [CNT_W-1:0] len_cur [N_PHASE];
  logic [CNT_W-1:0] start_len;
  phase_e           nxt;
  logic             nxt_ok;

  genvar g;
  generate
    for (g = 0; g < N_PHASE; g++) begin : g_len
      assign len_cur[g] = phase_len(work_cfg, ovf_cur, 2'(g));
    end
  endgenerate

  assign start_len = phase_len(next_cfg, start_ovf, 2'd0);

  // Earliest later phase with a nonzero length
  always_comb begin
    nxt_ok = 1'b0;
    nxt    = PH_P1;
    for (int k = N_PHASE - 1; k >= 1; k--) begin
      if ((k > int'(ph)) && (len_cur[k] != '0)) begin
        nxt_ok = 1'b1;
        nxt    = phase_e'(k[1:0]);
      end
    end
  end

  assign cyc_end = (rem == CNT_W'(1)) && !nxt_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph  <= PH_P1;
      rem <= '0;
    end else if (restart || cyc_end) begin
      ph  <= PH_P1;
      rem <= start_len;
    end else if (rem == CNT_W'(1)) begin
      ph  <= nxt;
      rem <= len_cur[nxt];
    end else begin
      rem <= rem - CNT_W'(1);
    end
  end

  assign phase = ph;

  // R4
  p3_type_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == PH_P3) |-> work_cfg.ptype[1]);

  // R4
  p4_type_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == PH_P4) |-> (work_cfg.ptype == PT_DIV4 || work_cfg.ptype == PT_DIV4N3));

endmodule

// File: rtl/fracn_mmd_ctrl.sv
module fracn_mmd_ctrl
  import fracn_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                en,
  input  logic                cfg_valid,
  output logic                cfg_ready,
  input  logic [PT_W-1:0]     cfg_ptype,
  input  logic [NM1_W-1:0]    cfg_nm1,
  input  logic [NM2_W-1:0]    cfg_nm2,
  input  logic [NM34_W-1:0]   cfg_nm3,
  input  logic [NM34_W-1:0]   cfg_nm4,
  input  logic [ACC_W-1:0]    frac_inc,
  input  logic                frac_mod8,
  output logic                fb1,
  output logic                fb2,
  output logic                div_pulse,
  output logic [ACC_W-1:0]    frac_acc
);

  logic      run_q;
  logic      active;
  logic      cyc_end;
  logic      ovf_flag;
  logic      ovf_new;
  logic      start_ovf;
  phase_e    phase;
  logic [1:0] code;
  work_cfg_t in_cfg;
  work_cfg_t work_cfg;
  work_cfg_t next_cfg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_q <= 1'b0;
    else        run_q <= en;
  end

  assign active    = run_q & en;
  assign start_ovf = active ? ovf_new : 1'b0;
  assign cfg_ready = !run_q | cyc_end;

  assign in_cfg = '{ptype: cfg_ptype, nm1: cfg_nm1, nm2: cfg_nm2, nm3: cfg_nm3, nm4: cfg_nm4};

  fracn_work_regs u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_cfg     (in_cfg),
    .load_valid (cfg_valid),
    .load_ready (cfg_ready),
    .work_cfg   (work_cfg),
    .next_cfg   (next_cfg)
  );

  fracn_frac_accum u_acc (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (!active),
    .step     (active & cyc_end),
    .inc      (frac_inc),
    .mod8     (frac_mod8),
    .acc      (frac_acc),
    .ovf_flag (ovf_flag),
    .ovf_new  (ovf_new)
  );

  fracn_phase_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .restart   (!active),
    .work_cfg  (work_cfg),
    .next_cfg  (next_cfg),
    .ovf_cur   (ovf_flag),
    .start_ovf (start_ovf),
    .phase     (phase),
    .cyc_end   (cyc_end)
  );

  assign code      = fb_code(phase);
  assign fb1       = run_q & code[1];
  assign fb2       = run_q & code[0];
  assign div_pulse = run_q & cyc_end;

  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!fb1 && !fb2 && !div_pulse));

  // R1
  restart_p1_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (div_pulse && en) |=> (fb1 && !fb2));

  // R5
  pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    div_pulse |=> !div_pulse);

endmodule

// File: tb/fracn_mmd_ctrl_test.sv
module fracn_mmd_ctrl_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0;
  logic        cfg_valid = 1'b0;
  logic        cfg_ready;
  logic [1:0]  cfg_ptype = 2'b01;
  logic [11:0] cfg_nm1 = '0;
  logic [7:0]  cfg_nm2 = '0;
  logic [3:0]  cfg_nm3 = '0;
  logic [3:0]  cfg_nm4 = '0;
  logic [2:0]  frac_inc = '0;
  logic        frac_mod8 = 1'b0;
  logic        fb1, fb2, div_pulse;
  logic [2:0]  frac_acc;

  always #5 clk = ~clk;

  fracn_mmd_ctrl uut (
    .clk(clk), .rst_n(rst_n), .en(en), .cfg_valid(cfg_valid), .cfg_ready(cfg_ready),
    .cfg_ptype(cfg_ptype), .cfg_nm1(cfg_nm1), .cfg_nm2(cfg_nm2), .cfg_nm3(cfg_nm3),
    .cfg_nm4(cfg_nm4), .frac_inc(frac_inc), .frac_mod8(frac_mod8),
    .fb1(fb1), .fb2(fb2), .div_pulse(div_pulse), .frac_acc(frac_acc)
  );

  int errors = 0;
  int checks = 0;
  bit done = 0;

  // bench model of the work registers and accumulator
  int m_pt = 1, m_nm1 = 0, m_nm2 = 0, m_nm3 = 0, m_nm4 = 0;
  int m_acc = 0;
  bit m_ov = 0;

  task automatic check(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  function automatic int exp_len(int p);
    case (p)
      0: return m_nm1 + (m_ov ? 1 : 2);
      1: return ((m_pt == 1) ? m_nm2 : (m_nm2 % 16)) + (m_ov ? 1 : 0);
      2: return (m_pt == 2 || m_pt == 3) ? m_nm3 + 1 : 0;
      default: return (m_pt == 3 || m_pt == 0) ? m_nm4 + 1 : 0;
    endcase
  endfunction

  function automatic void model_step(int nf, bit m8);
    int s, q;
    s = m_acc + nf;
    q = m8 ? 8 : 5;
    if (s >= q) begin m_ov = 1; m_acc = (s - q) % 8; end
    else begin m_ov = 0; m_acc = s; end
  endfunction

  // Follows one full main cycle; the load request and the fractional
  // inputs given here are driven in its first cycle and act at its end.
  task automatic main_cycle(input string tag, input bit do_load, input int l_pt, input int l_nm1,
                            input int l_nm2, input int l_nm3, input int l_nm4,
                            input int nf, input bit m8);
    int lens[4];
    int codes[4];
    int total, idx;
    int fb_a, fb_e, pl_a, pl_e, rd_a, rd_e;
    bit fb_ok, pl_ok, rd_ok, last;
    codes = '{2, 0, 1, 3};
    total = 0;
    for (int p = 0; p < 4; p++) begin lens[p] = exp_len(p); total += lens[p]; end
    idx = 0; fb_ok = 1; pl_ok = 1; rd_ok = 1;
    fb_a = 0; fb_e = 0; pl_a = 0; pl_e = 0; rd_a = 0; rd_e = 0;
    for (int p = 0; p < 4; p++) begin
      for (int c = 0; c < lens[p]; c++) begin
        @(negedge clk);
        idx++;
        last = (idx == total);
        if (fb_ok && ({fb1, fb2} != 2'(codes[p]))) begin
          fb_ok = 0; fb_a = int'({fb1, fb2}); fb_e = codes[p];
        end
        if (pl_ok && (div_pulse != last)) begin
          pl_ok = 0; pl_a = int'(div_pulse); pl_e = int'(last);
        end
        if (rd_ok && (cfg_ready != last)) begin
          rd_ok = 0; rd_a = int'(cfg_ready); rd_e = int'(last);
        end
        if (idx == 1) begin
          check(frac_acc == 3'(m_acc), {tag, " R6 accumulator at cycle start"}, int'(frac_acc), m_acc);
          frac_inc  = 3'(nf);
          frac_mod8 = m8;
          cfg_valid = do_load;
          if (do_load) begin
            cfg_ptype = 2'(l_pt); cfg_nm1 = 12'(l_nm1); cfg_nm2 = 8'(l_nm2);
            cfg_nm3 = 4'(l_nm3); cfg_nm4 = 4'(l_nm4);
          end
        end
      end
    end
    check(fb_ok, {tag, " R1/R2/R3/R4/R7 modulus-control sequence"}, fb_a, fb_e);
    check(pl_ok, {tag, " R5 end-of-cycle pulse"}, pl_a, pl_e);
    check(rd_ok, {tag, " R8 load window"}, rd_a, rd_e);
    if (do_load) begin
      m_pt = l_pt; m_nm1 = l_nm1; m_nm2 = l_nm2; m_nm3 = l_nm3; m_nm4 = l_nm4;
    end
    model_step(nf, m8);
  endtask

  initial begin
    void'($urandom(32'h5EED_0A17));
    repeat (3) @(negedge clk);
    // R10 reset state
    check({fb1, fb2} == 2'b00, "R10 control lines in reset", int'({fb1, fb2}), 0);
    check(div_pulse == 1'b0, "R10 pulse in reset", int'(div_pulse), 0);
    check(frac_acc == 3'd0, "R10 accumulator in reset", int'(frac_acc), 0);
    check(cfg_ready == 1'b1, "R10 R8 ready while idle", int'(cfg_ready), 1);
    rst_n = 1'b1;
    @(negedge clk);
    en = 1'b1;

    main_cycle("R10 default", 0, 0, 0, 0, 0, 0, 0, 0);
    main_cycle("R10 default", 1, 1, 3, 200, 0, 0, 2, 0);
    for (int i = 0; i < 5; i++) main_cycle("R3 wide NM2 R7", 0, 0, 0, 0, 0, 0, 2, 0);
    main_cycle("R4 load type 00", 1, 0, 5, 8'hA7, 6, 9, 3, 0);
    for (int i = 0; i < 4; i++) main_cycle("R4 type 00 skips P3", 0, 0, 0, 0, 0, 0, 3, 0);
    main_cycle("R3 load type 10", 1, 2, 2, 8'hF3, 2, 5, 1, 1);
    for (int i = 0; i < 4; i++) main_cycle("R3 narrow NM2", 0, 0, 0, 0, 0, 0, 4, 1);
    main_cycle("R3 load empty P2", 1, 1, 0, 0, 0, 0, 3, 1);
    for (int i = 0; i < 6; i++) main_cycle("R3 empty P2 R7", 0, 0, 0, 0, 0, 0, 3, 1);
    main_cycle("R2 load max NM1", 1, 3, 4095, 1, 0, 0, 0, 1);
    main_cycle("R2 max NM1", 1, 3, 1, 2, 3, 4, 0, 1);
    for (int i = 0; i < 8; i++) main_cycle("R6 modulo 8 step 7", 0, 0, 0, 0, 0, 0, 7, 1);
    for (int i = 0; i < 6; i++) main_cycle("R6 modulo 5 step 4", 0, 0, 0, 0, 0, 0, 4, 0);

    for (int i = 0; i < 250; i++) begin
      bit ld;
      ld = ($urandom % 4) == 0;
      main_cycle("random", ld, int'($urandom % 4), int'($urandom % 31), int'($urandom % 64),
                 int'($urandom % 16), int'($urandom % 16), int'($urandom % 8), bit'($urandom % 2));
    end

    // R9 disable mid-cycle, then load while idle and restart
    @(negedge clk);
    cfg_valid = 1'b0;
    en = 1'b0;
    frac_inc = 3'd7;
    @(negedge clk);
    check({fb1, fb2} == 2'b00, "R9 control lines while disabled", int'({fb1, fb2}), 0);
    check(div_pulse == 1'b0, "R9 pulse while disabled", int'(div_pulse), 0);
    check(cfg_ready == 1'b1, "R8 ready while disabled", int'(cfg_ready), 1);
    cfg_valid = 1'b1;
    cfg_ptype = 2'b11; cfg_nm1 = 12'd1; cfg_nm2 = 8'd2; cfg_nm3 = 4'd3; cfg_nm4 = 4'd4;
    repeat (3) @(negedge clk);
    check(frac_acc == 3'd0, "R9 accumulator cleared while disabled", int'(frac_acc), 0);
    cfg_valid = 1'b0;
    en = 1'b1;
    m_pt = 3; m_nm1 = 1; m_nm2 = 2; m_nm3 = 3; m_nm4 = 4; m_acc = 0; m_ov = 0;
    for (int i = 0; i < 5; i++) main_cycle("R9 restart", 0, 0, 0, 0, 0, 0, 5, 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule